// File: doc/BRIEF.md
# Clock Reference Selector with Phase/Frequency Detector

This block picks the frequency reference for an external voltage-controlled oscillator loop and compares it against the oscillator output, giving digital UP and DOWN pulses to an off-block loop filter. Four candidates can serve as the reference. Two are crystal clocks: a fast one for the 48 kHz family and a slower one for the 44.1 kHz family. The other two are external wordclocks, one from a coaxial receiver and one from a backplane pin. Each crystal is divided by `XTAL_DIV` in its own clock domain. Every candidate is then brought into the oscillator domain by a two-flop synchronizer with rising-edge detection. The oscillator clock itself is divided by `FB_DIV` to form the feedback edge.

A 4-bit control word, loaded from a simple write port, sets the source, a double-speed flag and a preview flag. The comparison always runs at the single-speed wordclock rate. In double-speed mode an external wordclock therefore has every other edge dropped, while the crystal references are never halved. The preview flag copies the synchronized coaxial wordclock onto `preview_out` so software can inspect it before selecting it. Changing the source clears the detector and the halving stage, so an edge left over from the old source cannot cause a large correction.

The detector is a four-state machine: `PFD_IDLE`, `PFD_UP`, `PFD_DN` and `PFD_BOTH`. From IDLE, a reference edge goes to UP, a feedback edge goes to DN, and both edges together go to BOTH. From UP, a feedback edge goes to BOTH. From DN, a reference edge goes to BOTH. BOTH always returns to IDLE on the next cycle. A source change forces IDLE from any state.

Top module: `clkref_selector`

## Requirements
- R1: The source field selects the reference: code 0 is the fast crystal, 1 the slow crystal, 2 the coaxial wordclock and 3 the backplane wordclock. Edges on any source that is not selected have no effect on `pfd_up` or `pfd_dn`.
- R2: On a cycle with `wr_en` high, `wr_data` is loaded into the control word. Bits [1:0] are the source, bit 2 is preview enable and bit 3 is double speed. After reset the control word is zero.
- R3: A crystal reference is divided by 512 and is never halved, even in double-speed mode. A crystal faster than the oscillator divided by 512 makes `pfd_up` high for more cycles than `pfd_dn`. A slower crystal does the opposite.
- R4: A feedback edge occurs every 512 oscillator cycles. The first one reaches the detector at the 512th rising edge after reset is released.
- R5: A rising edge on the selected external wordclock raises `pfd_up` at the third oscillator rising edge after the input changes (two synchronizer flops, then the detector register).
- R6: A reference edge sets UP and a feedback edge sets DOWN. When both are set, both outputs are high for exactly one cycle and then both go low. Further reference edges while UP is set have no effect.
- R7: In double-speed mode with an external source, the first reference edge after a clear is dropped and the second one is passed, alternating from then on.
- R8: A write that changes the source field puts both detector outputs low on the next cycle and resets the halving stage. A write that keeps the same source does not disturb the detector.
- R9: `preview_out` is the preview bit ANDed with the synchronized coaxial wordclock, registered. It is low whenever the preview bit is clear.
- R10: During reset `pfd_up`, `pfd_dn` and `preview_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Oscillator clock; all detector logic runs on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| xtal_hi_clk | input | 1 | Fast crystal clock (48 kHz family) |
| xtal_lo_clk | input | 1 | Slow crystal clock (44.1 kHz family) |
| bnc_wck | input | 1 | Wordclock from the coaxial receiver |
| bkpl_wck | input | 1 | Wordclock from the backplane pin |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 4 | Control word: source, preview, double speed |
| pfd_up | output | 1 | Detector UP pulse toward the loop filter |
| pfd_dn | output | 1 | Detector DOWN pulse toward the loop filter |
| preview_out | output | 1 | Synchronized coaxial wordclock, gated by preview |

## Verification
Faults show up in different places and at different speeds. A detector stuck in a wrong state shows at the ports at once, as UP and DOWN held together for more than one cycle, or as UP dropping with no feedback edge. A halving stage that was not cleared shows one edge later, when a single edge after a source change raises UP when it should not. A feedback divider that runs at the wrong rate only appears at the next expected feedback cycle. That can be up to 512 cycles later, so the bench samples exactly at those phases. A crystal divider at the wrong ratio only shows over thousands of cycles, as the wrong one of UP or DOWN dominating.

// File: rtl/clkref_pkg.sv
`timescale 1ns/1ps
package clkref_pkg;

    localparam int NUM_SRC = 4;

    typedef enum logic [1:0] {
        SRC_XTAL_HI = 2'd0,
        SRC_XTAL_LO = 2'd1,
        SRC_BNC     = 2'd2,
        SRC_BKPL    = 2'd3
    } src_e;

    typedef struct packed {
        logic dbl;
        logic pview;
        src_e src;
    } ctrl_t;

    typedef enum logic [1:0] {
        PFD_IDLE = 2'd0,
        PFD_UP   = 2'd1,
        PFD_DN   = 2'd2,
        PFD_BOTH = 2'd3
    } pfd_state_e;

endpackage

// File: rtl/clkref_xtal_div.sv
`timescale 1ns/1ps
// Divides a crystal clock by DIV (power of two) in the crystal's own domain.
module clkref_xtal_div #(
    parameter int DIV = 512
) (
    input  logic clk,
    input  logic rst_n,
    output logic div_out
);
    localparam int W = $clog2(DIV);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign div_out = cnt_q[W-1];
endmodule

// File: rtl/clkref_sync_edge.sv
`timescale 1ns/1ps
// Multi-flop synchronizer with rising-edge detect on the synchronized level.
module clkref_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], din};
    end

    assign level = sh_q[STAGES-1];
    assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/clkref_ref_cond.sv
`timescale 1ns/1ps
// Picks the selected edge and halves external edges in double-speed mode.
module clkref_ref_cond
    import clkref_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  src_e               src,
    input  logic               dbl,
    input  logic [NUM_SRC-1:0] rise,
    output logic               ref_edge
);
    logic sel_rise;
    logic halve;
    logic half_q;

    assign sel_rise = rise[src];
    assign halve    = dbl & src[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 half_q <= 1'b0;
        else if (clear)             half_q <= 1'b0;
        else if (sel_rise && halve) half_q <= ~half_q;
    end

    assign ref_edge = sel_rise && !clear && (!halve || half_q);
endmodule

// File: rtl/clkref_pfd.sv
`timescale 1ns/1ps
// Tri-state phase/frequency detector as an explicit state machine.
module clkref_pfd
    import clkref_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic ref_edge,
    input  logic fb_edge,
    output logic up,
    output logic dn
);
    pfd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PFD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = PFD_IDLE;
        end else begin
            unique case (state_q)
                PFD_IDLE: begin
                    if (ref_edge && fb_edge) state_d = PFD_BOTH;
                    else if (ref_edge)       state_d = PFD_UP;
                    else if (fb_edge)        state_d = PFD_DN;
                end
                PFD_UP:   if (fb_edge)  state_d = PFD_BOTH;
                PFD_DN:   if (ref_edge) state_d = PFD_BOTH;
                PFD_BOTH: state_d = PFD_IDLE;
            endcase
        end
    end

    always_comb begin
        up = 1'b0;
        dn = 1'b0;
        unique case (state_q)
            PFD_IDLE: ;
            PFD_UP:   up = 1'b1;
            PFD_DN:   dn = 1'b1;
            PFD_BOTH: begin up = 1'b1; dn = 1'b1; end
        endcase
    end
endmodule

// File: rtl/clkref_selector.sv
`timescale 1ns/1ps
module clkref_selector
    import clkref_pkg::*;
#(
    parameter int XTAL_DIV    = 512,
    parameter int FB_DIV      = 512,
    parameter int SYNC_STAGES = 2
) (
    input  logic       vco_clk,
    input  logic       rst_n,
    input  logic       xtal_hi_clk,
    input  logic       xtal_lo_clk,
    input  logic       bnc_wck,
    input  logic       bkpl_wck,
    input  logic       wr_en,
    input  logic [3:0] wr_data,
    output logic       pfd_up,
    output logic       pfd_dn,
    output logic       preview_out
);
    localparam int FB_W   = $clog2(FB_DIV);
    localparam int N_XTAL = 2;

    ctrl_t               ctrl_q;
    logic                src_change;
    logic [N_XTAL-1:0]   xtal_clk;
    logic [N_XTAL-1:0]   xtal_div;
    logic [NUM_SRC-1:0]  raw_lvl;
    logic [NUM_SRC-1:0]  sync_lvl;
    logic [NUM_SRC-1:0]  sync_rise;
    logic                ref_edge;
    logic                fb_edge;
    logic [FB_W-1:0]     fb_cnt_q;
    logic                prev_q;
    logic                unused_lvl;

    // control word
    always_ff @(posedge vco_clk or negedge rst_n) begin
        if (!rst_n)     ctrl_q <= '0;
        else if (wr_en) ctrl_q <= ctrl_t'(wr_data);
    end

    assign src_change = wr_en && (src_e'(wr_data[1:0]) != ctrl_q.src);

    // crystal pre-dividers, one per crystal domain
    assign xtal_clk = {xtal_lo_clk, xtal_hi_clk};
    for (genvar gx = 0; gx < N_XTAL; gx++) begin : g_xtal
        clkref_xtal_div #(.DIV(XTAL_DIV)) u_div (
            .clk     (xtal_clk[gx]),
            .rst_n   (rst_n),
            .div_out (xtal_div[gx])
        );
    end

    // index matches the source code
    assign raw_lvl = {bkpl_wck, bnc_wck, xtal_div[1], xtal_div[0]};

    for (genvar gs = 0; gs < NUM_SRC; gs++) begin : g_sync
        clkref_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (vco_clk),
            .rst_n (rst_n),
            .din   (raw_lvl[gs]),
            .level (sync_lvl[gs]),
            .rise  (sync_rise[gs])
        );
    end

    assign unused_lvl = ^{sync_lvl[SRC_XTAL_HI], sync_lvl[SRC_XTAL_LO], sync_lvl[SRC_BKPL]};

    clkref_ref_cond u_cond (
        .clk      (vco_clk),
        .rst_n    (rst_n),
        .clear    (src_change),
        .src      (ctrl_q.src),
        .dbl      (ctrl_q.dbl),
        .rise     (sync_rise),
        .ref_edge (ref_edge)
    );

    // feedback divider
    always_ff @(posedge vco_clk or negedge rst_n) begin
        if (!rst_n)       fb_cnt_q <= '0;
        else if (fb_edge) fb_cnt_q <= '0;
        else              fb_cnt_q <= fb_cnt_q + 1'b1;
    end

    assign fb_edge = (fb_cnt_q == FB_W'(FB_DIV - 1));

    clkref_pfd u_pfd (
        .clk      (vco_clk),
        .rst_n    (rst_n),
        .clear    (src_change),
        .ref_edge (ref_edge),
        .fb_edge  (fb_edge),
        .up       (pfd_up),
        .dn       (pfd_dn)
    );

    // preview path
    always_ff @(posedge vco_clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= ctrl_q.pview & sync_lvl[SRC_BNC];
    end

    assign preview_out = prev_q;
endmodule

// File: rtl/clkref_selector_chk.sv
`timescale 1ns/1ps
module clkref_selector_chk
    import clkref_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_src,
    input ctrl_t      ctrl,
    input logic       up,
    input logic       dn,
    input logic       prev_out,
    input logic       ref_edge,
    input logic       fb_edge
);
    a_r6_both_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (up && dn) |=> (!up && !dn));

    a_r8_src_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_src != ctrl.src)) |=> (!up && !dn));

    a_r9_preview_low: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.pview |=> !prev_out);

    a_r5_up_needs_ref: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up) |-> $past(ref_edge));

    a_r4_dn_needs_fb: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn) |-> $past(fb_edge));

    a_r6_up_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (up && !dn && !fb_edge && !(wr_en && (wr_src != ctrl.src))) |=> up);
endmodule

bind clkref_selector clkref_selector_chk u_chk (
    .clk      (vco_clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_src   (wr_data[1:0]),
    .ctrl     (ctrl_q),
    .up       (pfd_up),
    .dn       (pfd_dn),
    .prev_out (preview_out),
    .ref_edge (ref_edge),
    .fb_edge  (fb_edge)
);

// File: tb/sim_clkref_selector.sv
`timescale 1ns/1ps
module sim_clkref_selector;
    localparam int CLK_PERIOD = 10;
    localparam int XHI_HALF   = 4;
    localparam int XLO_HALF   = 6;
    localparam int FB_PER     = 512;
    localparam int WD_LIMIT   = 150000;

    logic       clk = 1'b0, xhi = 1'b0, xlo = 1'b0;
    logic       rst_n = 1'b0;
    logic       bnc = 1'b0, bkpl = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = 4'd0;
    logic       up, dn, prev;

    int errors = 0, checks = 0, cyc = 0, wd = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(XHI_HALF) xhi = ~xhi;
    always #(XLO_HALF) xlo = ~xlo;

    clkref_selector u0 (
        .vco_clk(clk), .rst_n(rst_n), .xtal_hi_clk(xhi), .xtal_lo_clk(xlo),
        .bnc_wck(bnc), .bkpl_wck(bkpl), .wr_en(wr_en), .wr_data(wr_data),
        .pfd_up(up), .pfd_dn(dn), .preview_out(prev)
    );

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > WD_LIMIT) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d expected<%0d", wd, WD_LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [3:0] ctrl_word(input logic [1:0] src, input bit pv, input bit ds);
        return {ds, pv, src};
    endfunction

    function automatic bit exp_prev(input bit pv, input bit lvl);
        return pv & lvl;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [3:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic force_idle(input logic [1:0] src, input bit ds);
        wr(ctrl_word(src ^ 2'b01, 1'b0, ds));
        wr(ctrl_word(src, 1'b0, ds));
    endtask

    task automatic wait_phase(input int p);
        step();
        while ((cyc % FB_PER) != p) step();
    endtask

    task automatic set_ext(input bit use_bkpl, input bit v);
        if (use_bkpl) bkpl = v; else bnc = v;
        repeat (3) step();
    endtask

    task automatic dominance(input int want_up, input string req);
        int ucnt = 0, dcnt = 0;
        repeat (1024) step();
        for (int i = 0; i < 8192; i++) begin
            step();
            ucnt += int'(up);
            dcnt += int'(dn);
        end
        if (want_up != 0) chk(ucnt > dcnt, req, ucnt, dcnt);
        else              chk(dcnt > ucnt, req, dcnt, ucnt);
    endtask

    initial begin
        void'($urandom(32'd2024));
        bnc = 1'b1;
        repeat (5) step();
        // R10: outputs low in reset
        chk(up == 0 && dn == 0 && prev == 0, "R10", {up, dn, prev}, 0);
        rst_n = 1'b1;
        repeat (6) step();
        // R2: reset control word has preview clear, so preview stays low
        chk(prev == 0, "R2", prev, 0);
        bnc = 1'b0;

        // R5/R6/R8: single speed, coaxial source
        wait_phase(50);
        force_idle(2'd2, 1'b0);
        chk(up == 0 && dn == 0, "R8", {up, dn}, 0);
        set_ext(1'b0, 1'b1);
        chk(up == 1 && dn == 0, "R5", {up, dn}, 2);
        set_ext(1'b0, 1'b0);
        set_ext(1'b0, 1'b1);
        chk(up == 1 && dn == 0, "R6", {up, dn}, 2);
        set_ext(1'b0, 1'b0);
        wr(ctrl_word(2'd2, 1'b0, 1'b0));
        step();
        chk(up == 1 && dn == 0, "R8", {up, dn}, 2);
        wait_phase(0);
        chk(up == 1 && dn == 1, "R4", {up, dn}, 3);
        step();
        chk(up == 0 && dn == 0, "R6", {up, dn}, 0);
        wait_phase(0);
        chk(up == 0 && dn == 1, "R4", {up, dn}, 1);
        wait_phase(50);
        set_ext(1'b0, 1'b1);
        chk(up == 1 && dn == 1, "R6", {up, dn}, 3);
        step();
        chk(up == 0 && dn == 0, "R6", {up, dn}, 0);
        set_ext(1'b0, 1'b0);

        // R7: double-speed halving, and halver reset by R8
        wait_phase(100);
        force_idle(2'd2, 1'b1);
        set_ext(1'b0, 1'b1);
        chk(up == 0, "R7", up, 0);
        set_ext(1'b0, 1'b0);
        force_idle(2'd2, 1'b1);
        set_ext(1'b0, 1'b1);
        chk(up == 0, "R8", up, 0);
        set_ext(1'b0, 1'b0);
        set_ext(1'b0, 1'b1);
        chk(up == 1, "R7", up, 1);
        set_ext(1'b0, 1'b0);

        // R1: backplane source, coaxial ignored
        wait_phase(200);
        force_idle(2'd3, 1'b0);
        set_ext(1'b0, 1'b1);
        chk(up == 0, "R1", up, 0);
        set_ext(1'b0, 1'b0);
        set_ext(1'b1, 1'b1);
        chk(up == 1, "R1", up, 1);
        set_ext(1'b1, 1'b0);

        // R3: crystal references
        force_idle(2'd0, 1'b0);
        dominance(1, "R3");
        force_idle(2'd1, 1'b0);
        dominance(0, "R3");
        force_idle(2'd0, 1'b1);
        dominance(1, "R3");

        // R9: preview path, directed then random
        wr(ctrl_word(2'd0, 1'b0, 1'b0));
        bnc = 1'b1; repeat (5) step();
        chk(prev == 0, "R9", prev, 0);
        wr(ctrl_word(2'd0, 1'b1, 1'b0));
        repeat (5) step();
        chk(prev == 1, "R9", prev, 1);
        for (int i = 0; i < 40; i++) begin
            bit pv, lvl, ds;
            logic [1:0] s;
            pv  = 1'($urandom_range(0, 1));
            lvl = 1'($urandom_range(0, 1));
            ds  = 1'($urandom_range(0, 1));
            s   = 2'($urandom_range(0, 3));
            wr(ctrl_word(s, pv, ds));
            bnc = lvl;
            repeat (5) step();
            chk(prev == exp_prev(pv, lvl), "R9", prev, exp_prev(pv, lvl));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule